// File: doc/BRIEF.md
# Single-Cycle 64-bit Integer Core (Eight-Operation Subset)

This block is a non-pipelined 64-bit processor core that retires exactly one instruction on every rising clock edge. In one cycle it fetches a 32-bit instruction word, decodes it, reads two source registers, computes a result and writes back. The writeback goes either to the register file or to data memory. A conditional branch can redirect the program counter in that same cycle. The supported operations are four register-register operations (add, subtract, AND, OR), add-immediate, a 64-bit doubleword load, a 64-bit doubleword store and branch-if-equal. Every other encoding retires as a no-op.

Instruction and data storage are arrays held inside the core. The test environment fills the instruction array while the core is held in reset. The data array is reached only through load and store instructions. For observation the core exposes its program counter and a combinational read port into the register file, selected by a register number.

Top module: `dwc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and all 32 registers become 0. After reset is released, the instruction at byte address 0 executes first.
- R2: Opcode bits[6:0]=0110011 is the register-register form, with rd in [11:7], rs1 in [19:15] and rs2 in [24:20]. It writes a result to rd: rs1+rs2 for funct7 [31:25]=0000000 with funct3 [14:12]=000, rs1-rs2 for funct7=0100000 with funct3=000, rs1&rs2 for funct7=0 with funct3=111, and rs1|rs2 for funct7=0 with funct3=110.
- R3: Opcode 0010011 with funct3=000 writes rs1 plus the sign-extended 12-bit immediate in bits[31:20] to rd.
- R4: Opcode 0000011 with funct3=011 loads the 64-bit doubleword at byte address rs1 + sign-extended bits[31:20] into rd. Address bits [2:0] are ignored, and the data array index wraps at its depth.
- R5: Opcode 0100011 with funct3=011 stores rs2 to the doubleword at rs1 + the sign-extended 12-bit immediate {bits[31:25], bits[11:7]}. It writes no register.
- R6: Opcode 1100011 with funct3=000 sets the PC to PC + offset when rs1 equals rs2, and to PC+4 otherwise. The offset is {bit31, bit7, bits[30:25], bits[11:8], 0}, sign-extended from 13 bits. Backward offsets are allowed, and the branch writes no register.
- R7: Each instruction completes, including writeback, within its own clock cycle, so the next instruction reads the new value with no gap.
- R8: Register 0 always reads as zero, and writes that name it as destination are discarded.
- R9: Any encoding not listed in R2 to R6 writes no register and no memory, and advances the PC by 4.
- R10: The reference sequence leaves register 5 = 40, 6 = 10, 7 = 7 and 8 = 15, with 40 stored at byte address 0 and 10 at byte address 8. In that sequence, registers 1 to 4 are set to 15, 25, 7 and 18, then added, subtracted, ANDed, ORed, stored and reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one instruction retires per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_sel | input | 5 | Register number for the observation read port |
| pc_o | output | 64 | Current program counter (address of the instruction now executing) |
| dbg_data | output | 64 | Combinational contents of register `dbg_sel` |

## Verification
The assertions assume that `rst` is held for at least one edge before the first instruction and that the instruction array is written only while the core is in reset. They also assume that every branch target stays inside the loaded program, since fetches past it would execute whatever the array holds. The random programs respect these limits. Loads and stores use register 0 as their base with offsets inside eight doubleword slots, and a prologue clears those slots. Forward branch offsets are clamped so that they land at or before a closing self-loop. Undecodable words use opcodes or function codes outside the subset, so the no-op rule is exercised without ever forming a legal encoding.

// File: rtl/dwc_pkg.sv
package dwc_pkg;

  localparam int XLEN = 64;

  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;
  localparam logic [6:0] OPC_BR    = 7'b1100011;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_op_e;
  typedef enum logic [1:0] {IMM_I, IMM_S, IMM_B} imm_sel_e;

  typedef struct packed {
    logic     reg_we;
    logic     mem_we;
    logic     mem_rd;
    logic     is_branch;
    logic     use_imm;
    alu_op_e  alu_op;
    imm_sel_e imm_sel;
  } ctrl_t;

  // 12-bit immediate from the top of the word, sign-extended
  function automatic logic [XLEN-1:0] imm_i(input logic [31:0] ins);
    return {{(XLEN-12){ins[31]}}, ins[31:20]};
  endfunction

  // store immediate split across two fields
  function automatic logic [XLEN-1:0] imm_s(input logic [31:0] ins);
    return {{(XLEN-12){ins[31]}}, ins[31:25], ins[11:7]};
  endfunction

  // branch offset, halfword granular, implicit zero LSB
  function automatic logic [XLEN-1:0] imm_b(input logic [31:0] ins);
    return {{(XLEN-13){ins[31]}}, ins[31], ins[7], ins[30:25], ins[11:8], 1'b0};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    case (op)
      ALU_ADD: r = a + b;
      ALU_SUB: r = a - b;
      ALU_AND: r = a & b;
      ALU_OR:  r = a | b;
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dwc_decode.sv
module dwc_decode
  import dwc_pkg::*;
(
  input  logic [31:0] ins,
  output ctrl_t       ctrl,
  output logic        legal,
  output logic [4:0]  rd,
  output logic [4:0]  rs1,
  output logic [4:0]  rs2
);

  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;

  assign opc = ins[6:0];
  assign f3  = ins[14:12];
  assign f7  = ins[31:25];
  assign rd  = ins[11:7];
  assign rs1 = ins[19:15];
  assign rs2 = ins[24:20];

  always_comb begin
    ctrl  = '{reg_we: 1'b0, mem_we: 1'b0, mem_rd: 1'b0, is_branch: 1'b0,
              use_imm: 1'b0, alu_op: ALU_ADD, imm_sel: IMM_I};
    legal = 1'b0;
    case (opc)
      OPC_REG: begin
        if (f7 == 7'b0000000 && f3 == 3'b000) begin
          legal = 1'b1; ctrl.alu_op = ALU_ADD;
        end else if (f7 == 7'b0100000 && f3 == 3'b000) begin
          legal = 1'b1; ctrl.alu_op = ALU_SUB;
        end else if (f7 == 7'b0000000 && f3 == 3'b111) begin
          legal = 1'b1; ctrl.alu_op = ALU_AND;
        end else if (f7 == 7'b0000000 && f3 == 3'b110) begin
          legal = 1'b1; ctrl.alu_op = ALU_OR;
        end
        ctrl.reg_we = legal;
      end
      OPC_IMM: if (f3 == 3'b000) begin
        legal = 1'b1; ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1;
      end
      OPC_LOAD: if (f3 == 3'b011) begin
        legal = 1'b1; ctrl.reg_we = 1'b1; ctrl.mem_rd = 1'b1; ctrl.use_imm = 1'b1;
      end
      OPC_STORE: if (f3 == 3'b011) begin
        legal = 1'b1; ctrl.mem_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.imm_sel = IMM_S;
      end
      OPC_BR: if (f3 == 3'b000) begin
        legal = 1'b1; ctrl.is_branch = 1'b1; ctrl.imm_sel = IMM_B;
      end
      default: legal = 1'b0;
    endcase
  end

  // R5/R6: a store or a branch never also writes a register
  always_comb begin
    a_r5_r6_exclusive_effects: assert ($onehot0({ctrl.reg_we, ctrl.mem_we, ctrl.is_branch}) || $isunknown(ins));
  end

  // R9: an undecodable word has no architectural effect besides the PC step
  always_comb begin
    a_r9_illegal_quiet: assert (legal || $isunknown(ins) ||
                                !(ctrl.reg_we || ctrl.mem_we || ctrl.is_branch));
  end

endmodule

// File: rtl/dwc_regfile.sv
module dwc_regfile #(
  parameter int NREGS = 32,
  parameter int W     = 64,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  input  logic [AW-1:0] ra3,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  output logic [W-1:0]  rd3,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);

  logic [W-1:0] regs [NREGS];
  logic         wr_fire;

  assign wr_fire = we && (wa != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_fire) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
  assign rd3 = (ra3 == '0) ? '0 : regs[ra3];

  // R7: a write lands by the next edge and is visible to the next instruction
  a_r7_write_visible: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> regs[$past(wa)] == $past(wd));

  // R8: a write naming register 0 leaves it unchanged
  a_r8_zero_kept: assert property (@(posedge clk) disable iff (rst)
    (we && wa == '0) |=> $stable(regs[0]));

endmodule

// File: rtl/dwc_imem.sv
module dwc_imem #(
  parameter int WORDS = 64,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic [IW-1:0] idx,
  output logic [31:0]   ins
);

  localparam logic [31:0] FILL_WORD = 32'h0000_0013;

  logic [31:0] mem [WORDS];

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = FILL_WORD;
  end

  assign ins = mem[idx];

endmodule

// File: rtl/dwc_dmem.sv
module dwc_dmem #(
  parameter int WORDS = 32,
  parameter int W     = 64,
  localparam int DW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] idx,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  rd
);

  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wd;
  end

  assign rd = mem[idx];

  // R5: stored doubleword is present in the slot on the following cycle
  a_r5_store_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(idx)] == $past(wd));

endmodule

// File: rtl/dwc_core.sv
module dwc_core
  import dwc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 32,
  localparam int IW        = $clog2(IMEM_WORDS),
  localparam int DW        = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [4:0]      dbg_sel,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] dbg_data
);

  logic [XLEN-1:0] pc_q, next_pc, seq_pc, br_target;
  logic [31:0]     ins;
  ctrl_t           ctrl;
  logic            legal;
  logic [4:0]      rd, rs1, rs2;
  logic [XLEN-1:0] rs1_val, rs2_val, imm, alu_b, alu_res, ld_data, wb_data;
  logic            br_taken;

  // fetch
  dwc_imem #(.WORDS(IMEM_WORDS)) u_imem (
    .idx (pc_q[IW+1:2]),
    .ins (ins)
  );

  // decode
  dwc_decode u_dec (
    .ins   (ins),
    .ctrl  (ctrl),
    .legal (legal),
    .rd    (rd),
    .rs1   (rs1),
    .rs2   (rs2)
  );

  // register file with a third port for observation
  dwc_regfile #(.NREGS(32), .W(XLEN)) u_rf (
    .clk (clk),
    .rst (rst),
    .ra1 (rs1),
    .ra2 (rs2),
    .ra3 (dbg_sel),
    .rd1 (rs1_val),
    .rd2 (rs2_val),
    .rd3 (dbg_data),
    .we  (ctrl.reg_we),
    .wa  (rd),
    .wd  (wb_data)
  );

  // immediate select
  always_comb begin
    case (ctrl.imm_sel)
      IMM_S:   imm = imm_s(ins);
      IMM_B:   imm = imm_b(ins);
      default: imm = imm_i(ins);
    endcase
  end

  // execute
  assign alu_b   = ctrl.use_imm ? imm : rs2_val;
  assign alu_res = alu_eval(ctrl.alu_op, rs1_val, alu_b);

  // data memory, doubleword indexed
  dwc_dmem #(.WORDS(DMEM_WORDS), .W(XLEN)) u_dmem (
    .clk (clk),
    .rst (rst),
    .we  (ctrl.mem_we),
    .idx (alu_res[DW+2:3]),
    .wd  (rs2_val),
    .rd  (ld_data)
  );

  assign wb_data = ctrl.mem_rd ? ld_data : alu_res;

  // next PC
  assign br_taken  = ctrl.is_branch && (rs1_val == rs2_val);
  assign seq_pc    = pc_q + XLEN'(4);
  assign br_target = pc_q + imm;
  assign next_pc   = br_taken ? br_target : seq_pc;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= next_pc;
  end

  assign pc_o = pc_q;

  // R1: reset forces the fetch address to zero
  a_r1_pc_reset: assert property (@(posedge clk) rst |=> pc_q == '0);

  // R6/R9: without a taken branch the PC moves by one word
  a_r6_sequential: assert property (@(posedge clk) disable iff (rst)
    !br_taken |=> pc_q == $past(pc_q) + XLEN'(4));

  // R6: a taken branch lands on PC plus the branch offset
  a_r6_taken: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> pc_q == $past(pc_q) + $past(imm_b(ins)));

  // R9: undecodable words never redirect the PC
  a_r9_no_redirect: assert property (@(posedge clk) disable iff (rst)
    !legal |-> !br_taken);

endmodule

// File: tb/test_dwc_core.sv
`timescale 1ns/1ps
module test_dwc_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  dbg_sel = '0;
  logic [63:0] pc_o, dbg_data;

  always #10 clk = ~clk;

  dwc_core i_dwc_core (
    .clk      (clk),
    .rst      (rst),
    .dbg_sel  (dbg_sel),
    .pc_o     (pc_o),
    .dbg_data (dbg_data)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [31:0] prog [64];
  logic [63:0] mreg [32];
  logic [63:0] mdm  [32];
  logic [63:0] mpc;

  task automatic check(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // encoders
  function automatic logic [31:0] e_r(int f7, int src2, int src1, int f3, int dst);
    logic [6:0] a = f7[6:0];
    return {a, src2[4:0], src1[4:0], f3[2:0], dst[4:0], 7'b0110011};
  endfunction
  function automatic logic [31:0] e_i(int imm, int src1, int f3, int dst, logic [6:0] op);
    return {imm[11:0], src1[4:0], f3[2:0], dst[4:0], op};
  endfunction
  function automatic logic [31:0] e_s(int off, int src2, int src1);
    return {off[11:5], src2[4:0], src1[4:0], 3'b011, off[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] e_b(int off, int src1, int src2);
    return {off[12], off[10:5], src2[4:0], src1[4:0], 3'b000, off[4:1], off[11], 7'b1100011};
  endfunction

  localparam logic [31:0] HALT = 32'h0000_0063; // branch to itself when x0==x0

  // reference model step; returns the requirement tag of the executed word
  function automatic string model_step();
    logic [31:0] w = prog[mpc[7:2]];
    logic [63:0] a, b, nxt, res;
    logic signed [11:0] ii, si;
    logic signed [12:0] bo;
    string t = "R9";
    int d = int'(w[11:7]);
    a = (w[19:15] == 0) ? 64'd0 : mreg[w[19:15]];
    b = (w[24:20] == 0) ? 64'd0 : mreg[w[24:20]];
    ii = w[31:20];
    si = {w[31:25], w[11:7]};
    bo = {w[31], w[7], w[30:25], w[11:8], 1'b0};
    nxt = mpc + 64'd4;
    case (w[6:0])
      7'b0110011: begin
        t = "R2";
        if (w[31:25] == 7'h00 && w[14:12] == 3'd0)      res = a + b;
        else if (w[31:25] == 7'h20 && w[14:12] == 3'd0) res = a - b;
        else if (w[31:25] == 7'h00 && w[14:12] == 3'd7) res = a & b;
        else if (w[31:25] == 7'h00 && w[14:12] == 3'd6) res = a | b;
        else t = "R9";
        if (t == "R2" && d != 0) mreg[d] = res;
      end
      7'b0010011: if (w[14:12] == 3'd0) begin
        t = "R3";
        if (d != 0) mreg[d] = a + 64'(longint'(ii));
      end
      7'b0000011: if (w[14:12] == 3'd3) begin
        t = "R4";
        res = a + 64'(longint'(ii));
        if (d != 0) mreg[d] = mdm[res[7:3]];
      end
      7'b0100011: if (w[14:12] == 3'd3) begin
        t = "R5";
        res = a + 64'(longint'(si));
        mdm[res[7:3]] = b;
      end
      7'b1100011: if (w[14:12] == 3'd0) begin
        t = "R6";
        if (a == b) nxt = mpc + 64'(longint'(bo));
      end
      default: t = "R9";
    endcase
    mpc = nxt;
    return t;
  endfunction

  task automatic clear_prog();
    for (int k = 0; k < 64; k++) prog[k] = HALT;
  endtask

  // R1: reset with program load, reset state observed at the ports
  task automatic start_prog();
    rst = 1'b1;
    for (int k = 0; k < 64; k++) i_dwc_core.u_imem.mem[k] = prog[k];
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", "pc in reset", pc_o, 64'd0);
    for (int r = 0; r < 32; r++) begin
      dbg_sel = 5'(r);
      #1 check("R1", $sformatf("x%0d in reset", r), dbg_data, 64'd0);
    end
    mpc = '0;
    for (int r = 0; r < 32; r++) mreg[r] = '0;
    rst = 1'b0;
  endtask

  task automatic run(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      string t = model_step();
      @(posedge clk);
      @(negedge clk);
      check(t, "pc after step (R7)", pc_o, mpc);
    end
  endtask

  task automatic cmp_regs();
    for (int r = 0; r < 32; r++) begin
      dbg_sel = 5'(r);
      #1 check(r == 0 ? "R8" : "R7", $sformatf("x%0d", r), dbg_data, mreg[r]);
    end
  endtask

  task automatic peek(input int r, output logic [63:0] v);
    dbg_sel = 5'(r);
    #1 v = dbg_data;
  endtask

  function automatic logic [31:0] rand_illegal();
    logic [31:0] w = $urandom;
    case ($urandom % 4)
      0: w[6:0] = 7'b0110111;
      1: w[6:0] = 7'b1101111;
      2: begin w[6:0] = 7'b0110011; w[14:12] = 3'b001; end
      default: begin w[6:0] = 7'b0010011; w[14:12] = 3'b100; end
    endcase
    return w;
  endfunction

  task automatic random_prog();
    int n = 0;
    clear_prog();
    for (int s = 0; s < 8; s++) prog[n++] = e_s(s * 8, 0, 0);
    for (int r = 1; r < 16; r++) prog[n++] = e_i(int'($urandom % 4096), 0, 0, r, 7'b0010011);
    for (int k = 0; k < 36; k++) begin
      int kind = int'($urandom % 7);
      int d = int'($urandom % 16), s1 = int'($urandom % 16), s2 = int'($urandom % 16);
      case (kind)
        0: begin
          int sel = int'($urandom % 4);
          case (sel)
            0: prog[n] = e_r(0, s2, s1, 0, d);
            1: prog[n] = e_r(32, s2, s1, 0, d);
            2: prog[n] = e_r(0, s2, s1, 7, d);
            default: prog[n] = e_r(0, s2, s1, 6, d);
          endcase
        end
        1: prog[n] = e_i(int'($urandom % 4096), s1, 0, d, 7'b0010011);
        2: prog[n] = e_i(int'($urandom % 8) * 8, 0, 3, d, 7'b0000011);
        3: prog[n] = e_s(int'($urandom % 8) * 8, s2, 0);
        4: begin
          int hop = 1 + int'($urandom % 3);
          if (n + hop > 59) hop = 59 - n;
          if (hop < 1) hop = 1;
          prog[n] = e_b(hop * 4, s1, ($urandom % 2) ? s1 : s2);
        end
        5: prog[n] = rand_illegal();
        default: prog[n] = e_r(0, s2, s1, 0, 0); // destination x0
      endcase
      n++;
    end
    prog[n] = HALT;
  endtask

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    void'($urandom(32'd2718));

    // R10 reference sequence, plus a discarded write to x0 (R8)
    clear_prog();
    prog[0]  = e_i(15, 0, 0, 1, 7'b0010011);
    prog[1]  = e_i(25, 0, 0, 2, 7'b0010011);
    prog[2]  = e_i(7, 0, 0, 3, 7'b0010011);
    prog[3]  = e_i(18, 0, 0, 4, 7'b0010011);
    prog[4]  = e_r(0, 2, 1, 0, 5);
    prog[5]  = e_r(32, 1, 2, 0, 6);
    prog[6]  = e_r(0, 3, 1, 7, 7);
    prog[7]  = e_r(0, 3, 1, 6, 8);
    prog[8]  = e_s(0, 5, 0);
    prog[9]  = e_s(8, 6, 0);
    prog[10] = e_i(0, 0, 3, 9, 7'b0000011);
    prog[11] = e_i(8, 0, 3, 10, 7'b0000011);
    prog[12] = e_i(5, 0, 0, 0, 7'b0010011);
    prog[13] = e_i(-3, 1, 0, 11, 7'b0010011); // negative immediate, R3
    start_prog();
    run(18);
    peek(5, v);  check("R10", "x5", v, 64'd40);
    peek(6, v);  check("R10", "x6", v, 64'd10);
    peek(7, v);  check("R10", "x7", v, 64'd7);
    peek(8, v);  check("R10", "x8", v, 64'd15);
    peek(9, v);  check("R10", "mem[0] via x9", v, 64'd40);
    peek(10, v); check("R10", "mem[8] via x10", v, 64'd10);
    peek(0, v);  check("R8", "x0 after write", v, 64'd0);
    peek(11, v); check("R3", "x11 negative imm", v, 64'd12);
    cmp_regs();

    // R6 backward branch loop computing the tenth Fibonacci number
    clear_prog();
    prog[0]  = e_i(10, 0, 0, 5, 7'b0010011);
    prog[1]  = e_s(0, 5, 0);
    prog[2]  = e_i(0, 0, 3, 1, 7'b0000011);
    prog[3]  = e_i(0, 0, 0, 2, 7'b0010011);
    prog[4]  = e_i(1, 0, 0, 3, 7'b0010011);
    prog[5]  = e_b(40, 1, 0);
    prog[6]  = e_i(-1, 1, 0, 1, 7'b0010011);
    prog[7]  = e_b(28, 1, 0);
    prog[8]  = e_r(0, 3, 2, 0, 4);
    prog[9]  = e_r(0, 0, 3, 0, 2);
    prog[10] = e_r(0, 0, 4, 0, 3);
    prog[11] = e_i(-1, 1, 0, 1, 7'b0010011);
    prog[12] = e_b(8, 1, 0);
    prog[13] = e_b(-20, 0, 0);
    prog[14] = e_r(0, 0, 3, 0, 4);
    start_prog();
    run(90);
    peek(4, v); check("R6", "loop result x4", v, 64'd55);
    check("R6", "parked pc", pc_o, 64'd60);
    cmp_regs();

    // R9 illegal word followed by a dependent add (R7)
    clear_prog();
    prog[0] = e_i(9, 0, 0, 1, 7'b0010011);
    prog[1] = 32'h1234_50b7; // outside the subset, names x1 as destination
    prog[2] = e_r(0, 1, 1, 0, 2);
    start_prog();
    run(5);
    peek(1, v); check("R9", "x1 untouched by illegal", v, 64'd9);
    peek(2, v); check("R7", "back-to-back x2", v, 64'd18);

    // constrained random programs
    for (int p = 0; p < 40; p++) begin
      random_prog();
      start_prog();
      run(63);
      cmp_regs();
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule